// File: doc/BRIEF.md
# Dual Accumulator Zeroing Controller

This block holds two 32-bit accumulators and decides, cycle by cycle, when each one is forced to zero. The frequency accumulator integrates a signed step whenever a step-enable input is high. The phase accumulator adds the base tuning word plus the current frequency accumulator value on every clock. Each accumulator has its own pair of zeroing controls, and the two pairs act independently.

The first control is a level-held clear, which keeps the accumulator at zero for as long as it is high. The second is a one-shot clear, armed by an auto bit. It zeroes the accumulator for a single cycle each time a qualifying event arrives. A qualifying event is an update strobe, or any change on the profile pins compared with their value in the previous cycle. The surrounding synthesizer uses these controls to restart phase or sweep coherently when it switches settings.

Top module: `acc_clear_ctrl`

## Requirements
- R1: While `hold_freq_clr` is sampled high on a clock edge, `freq_acc` reads zero after that edge.
- R2: While `hold_phase_clr` is sampled high on a clock edge, `phase_acc` reads zero after that edge.
- R3: With `auto_freq_clr` high, an `io_update` pulse sampled on an edge makes `freq_acc` zero after that edge, and accumulation resumes on the next edge.
- R4: With `auto_phase_clr` high, an `io_update` pulse sampled on an edge makes `phase_acc` zero after that edge, and accumulation resumes on the next edge.
- R5: A change on any bit of `profile` relative to its value sampled on the previous edge is a clear event equal to `io_update`. The reference copy is zero after reset.
- R6: The one-shot clear repeats on every event while the auto bit is high. With the auto bit low, events have no effect on that accumulator.
- R7: The frequency controls never zero `phase_acc`, and the phase controls never zero `freq_acc`.
- R8: When a level-held clear and a one-shot clear apply together, the accumulator reads zero and the level-held clear governs.
- R9: When no clear applies, `freq_acc` adds the two's-complement `freq_step` on each edge where `step_en` is high, modulo 2^32, and holds otherwise.
- R10: When no clear applies, `phase_acc` adds `base_ftw + freq_acc` (the values before the edge) on every edge, modulo 2^32.
- R11: After a synchronous reset, both accumulators read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_freq_clr | input | 1 | Arms one-shot clear of the frequency accumulator |
| auto_phase_clr | input | 1 | Arms one-shot clear of the phase accumulator |
| hold_freq_clr | input | 1 | Level-held clear of the frequency accumulator |
| hold_phase_clr | input | 1 | Level-held clear of the phase accumulator |
| io_update | input | 1 | Update strobe, a clear event |
| profile | input | 2 | Profile pins; any change is a clear event |
| step_en | input | 1 | Frequency step enable |
| freq_step | input | 32 | Signed frequency step |
| base_ftw | input | 32 | Base frequency tuning word |
| freq_acc | output | 32 | Frequency accumulator value |
| phase_acc | output | 32 | Phase accumulator value |

## Verification
A wrong event decision or clear priority shows on the accumulator outputs one edge after the stimulus. Either a value fails to reach zero, or a zero appears that should not be there. A frozen profile copy or a sticky clear shows on the edge after that, because accumulation fails to resume. An error in the frequency accumulator also spreads into the phase accumulator on the following edge, since the phase adds it every cycle. Comparing both outputs on every cycle of a sweep over all sixteen control settings and all event kinds therefore catches a fault within two cycles.

// File: rtl/acc_clr_pkg.sv
package acc_clr_pkg;
  typedef enum logic [1:0] {
    CLR_RUN   = 2'd0,
    CLR_HOLD  = 2'd1,
    CLR_PULSE = 2'd2
  } clr_kind_e;

  localparam int unsigned NUM_ACC = 2;
  localparam int unsigned IDX_FREQ = 0;
  localparam int unsigned IDX_PHASE = 1;
endpackage

// File: rtl/clr_event_det.sv
module clr_event_det #(
  parameter int unsigned PROF_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_update,
  input  logic [PROF_W-1:0] profile,
  output logic              evt
);
  logic [PROF_W-1:0] prof_q;

  always_ff @(posedge clk) begin
    if (rst) prof_q <= '0;
    else     prof_q <= profile;
  end

  always_comb evt = io_update | (|(profile ^ prof_q));
endmodule

// File: rtl/clr_select.sv
module clr_select
  import acc_clr_pkg::*;
(
  input  logic      hold_clr,
  input  logic      auto_clr,
  input  logic      evt,
  output clr_kind_e kind
);
  always_comb begin
    if (hold_clr)             kind = CLR_HOLD;
    else if (auto_clr && evt) kind = CLR_PULSE;
    else                      kind = CLR_RUN;
  end
endmodule

// File: rtl/freq_accum.sv
module freq_accum
  import acc_clr_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  clr_kind_e        kind,
  input  logic             step_en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (rst)                   acc <= '0;
    else if (kind != CLR_RUN)  acc <= '0;
    else if (step_en)          acc <= acc + step;
  end
endmodule

// File: rtl/phase_accum.sv
module phase_accum
  import acc_clr_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  clr_kind_e        kind,
  input  logic [ACC_W-1:0] base,
  input  logic [ACC_W-1:0] offs,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] ftw_eff;

  always_comb ftw_eff = base + offs;

  always_ff @(posedge clk) begin
    if (rst)                  acc <= '0;
    else if (kind != CLR_RUN) acc <= '0;
    else                      acc <= acc + ftw_eff;
  end
endmodule

// File: rtl/acc_clear_ctrl.sv
module acc_clear_ctrl
  import acc_clr_pkg::*;
#(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned PROF_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_freq_clr,
  input  logic              auto_phase_clr,
  input  logic              hold_freq_clr,
  input  logic              hold_phase_clr,
  input  logic              io_update,
  input  logic [PROF_W-1:0] profile,
  input  logic              step_en,
  input  logic [ACC_W-1:0]  freq_step,
  input  logic [ACC_W-1:0]  base_ftw,
  output logic [ACC_W-1:0]  freq_acc,
  output logic [ACC_W-1:0]  phase_acc
);
  logic               evt;
  logic [NUM_ACC-1:0] hold_v;
  logic [NUM_ACC-1:0] auto_v;
  clr_kind_e          kind_v [NUM_ACC];

  always_comb begin
    hold_v[IDX_FREQ]  = hold_freq_clr;
    hold_v[IDX_PHASE] = hold_phase_clr;
    auto_v[IDX_FREQ]  = auto_freq_clr;
    auto_v[IDX_PHASE] = auto_phase_clr;
  end

  clr_event_det #(.PROF_W(PROF_W)) u_evt (
    .clk(clk), .rst(rst), .io_update(io_update), .profile(profile), .evt(evt)
  );

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_sel
    clr_select u_sel (
      .hold_clr(hold_v[g]), .auto_clr(auto_v[g]), .evt(evt), .kind(kind_v[g])
    );
  end

  freq_accum #(.ACC_W(ACC_W)) u_facc (
    .clk(clk), .rst(rst), .kind(kind_v[IDX_FREQ]), .step_en(step_en),
    .step(freq_step), .acc(freq_acc)
  );

  phase_accum #(.ACC_W(ACC_W)) u_pacc (
    .clk(clk), .rst(rst), .kind(kind_v[IDX_PHASE]), .base(base_ftw),
    .offs(freq_acc), .acc(phase_acc)
  );
endmodule

// File: rtl/acc_clear_ctrl_chk.sv
module acc_clear_ctrl_chk #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned PROF_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              auto_freq_clr,
  input logic              auto_phase_clr,
  input logic              hold_freq_clr,
  input logic              hold_phase_clr,
  input logic              io_update,
  input logic [PROF_W-1:0] profile,
  input logic              step_en,
  input logic [ACC_W-1:0]  freq_step,
  input logic [ACC_W-1:0]  base_ftw,
  input logic [ACC_W-1:0]  freq_acc,
  input logic [ACC_W-1:0]  phase_acc
);
  logic [PROF_W-1:0] seen_prof;
  logic              chg;

  always_ff @(posedge clk) begin
    if (rst) seen_prof <= '0;
    else     seen_prof <= profile;
  end
  always_comb chg = (profile != seen_prof);

  a_r1_hold_freq: assert property (@(posedge clk) disable iff (rst)
    hold_freq_clr |=> freq_acc == '0);
  a_r2_hold_phase: assert property (@(posedge clk) disable iff (rst)
    hold_phase_clr |=> phase_acc == '0);
  a_r3_upd_freq: assert property (@(posedge clk) disable iff (rst)
    (auto_freq_clr && io_update) |=> freq_acc == '0);
  a_r4_upd_phase: assert property (@(posedge clk) disable iff (rst)
    (auto_phase_clr && io_update) |=> phase_acc == '0);
  a_r5_prof_freq: assert property (@(posedge clk) disable iff (rst)
    (auto_freq_clr && chg) |=> freq_acc == '0);
  a_r9_freq_idle: assert property (@(posedge clk) disable iff (rst)
    (!hold_freq_clr && !auto_freq_clr && !step_en) |=> $stable(freq_acc));
  a_r10_phase_run: assert property (@(posedge clk) disable iff (rst)
    (!hold_phase_clr && !(auto_phase_clr && (io_update || chg)))
    |=> phase_acc == $past(phase_acc + base_ftw + freq_acc));
endmodule

bind acc_clear_ctrl acc_clear_ctrl_chk #(.ACC_W(ACC_W), .PROF_W(PROF_W)) u_chk (
  .clk(clk), .rst(rst), .auto_freq_clr(auto_freq_clr), .auto_phase_clr(auto_phase_clr),
  .hold_freq_clr(hold_freq_clr), .hold_phase_clr(hold_phase_clr), .io_update(io_update),
  .profile(profile), .step_en(step_en), .freq_step(freq_step), .base_ftw(base_ftw),
  .freq_acc(freq_acc), .phase_acc(phase_acc)
);

// File: tb/acc_clear_ctrl_test.sv
module acc_clear_ctrl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        af, ap, hf, hp, upd, sen;
  logic [1:0]  prof;
  logic [31:0] step, base;
  logic [31:0] facc, pacc;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_f, exp_p;
  logic [1:0]  prev_prof;

  always #5 clk = ~clk;

  acc_clear_ctrl uut (
    .clk(clk), .rst(rst), .auto_freq_clr(af), .auto_phase_clr(ap),
    .hold_freq_clr(hf), .hold_phase_clr(hp), .io_update(upd), .profile(prof),
    .step_en(sen), .freq_step(step), .base_ftw(base), .freq_acc(facc), .phase_acc(pacc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Drives one cycle at a falling edge, predicts, and compares at the next falling edge.
  task automatic cyc(input logic [3:0] ctl, input logic u, input logic [1:0] p,
                     input logic se, input logic [31:0] st, input logic [31:0] bs);
    logic ev;
    logic [31:0] nf, np;
    string tf, tp;
    {hf, hp, af, ap} = ctl;
    upd = u; prof = p; sen = se; step = st; base = bs;
    ev = u | (p != prev_prof);
    if (hf) begin nf = '0; tf = (af && ev) ? "R8" : "R1"; end
    else if (af && ev) begin nf = '0; tf = u ? "R3" : "R5"; end
    else begin
      nf = se ? exp_f + st : exp_f;
      tf = hp || (ap && ev) ? "R7" : (ev ? "R6" : "R9");
    end
    if (hp) begin np = '0; tp = (ap && ev) ? "R8" : "R2"; end
    else if (ap && ev) begin np = '0; tp = u ? "R4" : "R5"; end
    else begin
      np = exp_p + bs + exp_f;
      tp = hf || (af && ev) ? "R7" : (ev ? "R6" : "R10");
    end
    exp_f = nf; exp_p = np; prev_prof = p;
    @(negedge clk);
    check(tf, facc, exp_f);
    check(tp, pacc, exp_p);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] pcur;
    rst = 1'b1; {hf, hp, af, ap} = '0; upd = 0; prof = '0; sen = 0; step = '0; base = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11", facc, 32'h0);
    check("R11", pacc, 32'h0);
    exp_f = '0; exp_p = '0; prev_prof = '0; pcur = '0;
    for (int ctl = 0; ctl < 16; ctl++) begin
      for (int evk = 0; evk < 4; evk++) begin
        logic [31:0] st;
        logic [31:0] bs;
        st = evk[0] ? -(32'h0001_0003 * (ctl + 1)) : 32'h0100_0001 * (ctl + 1);
        bs = 32'h1234_5678 ^ ctl;
        cyc(4'b0000, 1'b0, pcur, 1'b1, st, bs);
        cyc(4'b0000, 1'b0, pcur, 1'b1, st, bs);
        if (evk >= 2) pcur = pcur + 2'd1;
        cyc(ctl[3:0], evk[0] || evk == 0, pcur, 1'b1, st, bs);
        cyc(ctl[3:0], 1'b0, pcur, 1'b1, st, bs);
        cyc(ctl[3:0], 1'b0, pcur, 1'b0, st, bs);
        pcur = pcur ^ 2'b10;
        cyc(ctl[3:0], 1'b0, pcur, 1'b1, st, bs);
        cyc(ctl[3:0], 1'b1, pcur, 1'b1, st, bs);
      end
    end
    // R9 wrap below zero from a cleared value
    cyc(4'b1000, 1'b0, pcur, 1'b0, 32'h0, 32'h0);
    cyc(4'b0000, 1'b0, pcur, 1'b1, 32'hFFFF_FFF0, 32'h8000_0000);
    check("R9", facc, 32'hFFFF_FFF0);
    cyc(4'b0000, 1'b0, pcur, 1'b1, 32'hFFFF_FFF0, 32'h8000_0000);
    check("R10", pacc, exp_p);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule